// File: doc/BRIEF.md
# SPI Flash Status Byte Responder

This block is the device-side logic of a serial flash that answers a status read and keeps the protection-lock bit. It follows SPI mode 0 with an active-low select. SCK, select and MOSI are oversampled by the fabric clock and passed through synchronizers. Opcode and data bits are taken on SCK rising edges, and MISO changes after SCK falling edges. High impedance is shown by a separate output-enable that a pad wrapper turns into a tri-state buffer.

After the read opcode, the block streams an eight-bit status word, most significant bit first. The word is rebuilt from the live inputs at every byte boundary, and the stream keeps going for as long as select stays low. The status word holds these inputs: busy, the write-enable latch, the write-protect pin, the error flag, and the stored lock bit. It also holds a two-bit summary of a vector of per-sector protection flags. A status write can change only the lock bit. The write takes effect when select rises on a clean byte boundary, and only if the write-enable latch was set. When the write takes effect, the block requests that the latch be cleared.

Top module: `spi_status_resp`

## Requirements
- R1: After synchronous reset, `miso_oe`, `lock_o` and `wel_clr_o` are all 0.
- R2: Opcode 0x05, sent MSB first, starts a status stream. `miso_oe` stays 0 while the opcode is being shifted in. The first status bit (bit 7) is valid for the SCK rising edge that comes right after the eighth opcode bit.
- R3: Status word layout: [7] lock, [6] constant 0, [5] error flag, [4] write-protect pin level (1 = pin inactive), [3:2] sector summary, [1] write-enable latch, [0] busy. The word can be read while busy is 1.
- R4: The sector summary reads 2'b00 when no sector flag is set, 2'b11 when every flag is set, and 2'b01 in all other cases. The value 2'b10 never appears.
- R5: While select stays low, the word repeats without a gap after bit 0. Each repetition reflects the inputs as they stood at the SCK falling edge that drives its bit 7. Input changes in the middle of a byte do not alter that byte.
- R6: Raising select at any point, including in the middle of a byte, drops `miso_oe` to 0 within five clock cycles. The next select-low period starts again from opcode decode.
- R7: Any opcode other than 0x05 or 0x01 keeps `miso_oe` at 0 until select rises.
- R8: Opcode 0x01 followed by one or more whole data bytes, ended by select rising on a byte boundary while `wel_i` is 1, loads bit 7 of the last data byte into `lock_o` and pulses `wel_clr_o` high for one cycle. No other status bit changes.
- R9: A status write with `wel_i` at 0, or one ended part-way through a byte, leaves `lock_o` unchanged and produces no `wel_clr_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock that oversamples the SPI pins |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low select |
| spi_mosi | input | 1 | Host-to-device data |
| spi_miso | output | 1 | Device-to-host data |
| spi_miso_oe | output | 1 | Drive enable for MISO; 0 means high impedance |
| busy_i | input | 1 | Internal operation in progress |
| wel_i | input | 1 | Write-enable latch state |
| wp_n_i | input | 1 | Write-protect pin level |
| err_i | input | 1 | Erase/program failure flag |
| sect_prot_i | input | NUM_SECT | Per-sector protection flags |
| lock_o | output | 1 | Stored sector-protection lock bit |
| wel_clr_o | output | 1 | One-cycle request to clear the write-enable latch |

## Verification
The byte-boundary snapshot can land in the same cycle as a change on the status inputs. The word then has to take one coherent set of values, never a mix of old and new bits. The bench provokes this by changing the inputs right after the final bit of one byte is sampled, so the change and the next falling SCK edge meet. It then changes the inputs again after three bits of the following byte. Each byte is judged against exactly one input set: the set that was present at its own boundary.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = $clog2(BYTE_W);
  localparam logic [BYTE_W-1:0] OPC_READ_DEF  = 8'h05;
  localparam logic [BYTE_W-1:0] OPC_WRITE_DEF = 8'h01;

  typedef enum logic [1:0] {
    PH_OPCODE = 2'd0,
    PH_STREAM = 2'd1,
    PH_WDATA  = 2'd2,
    PH_SKIP   = 2'd3
  } phase_t;
endpackage

// File: rtl/spi_stat_sync.sv
module spi_stat_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] pipe [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) pipe[0] <= RST_VAL;
          else     pipe[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) pipe[g] <= RST_VAL;
          else     pipe[g] <= pipe[g-1];
        end
      end
    end
  endgenerate

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/spi_stat_summary.sv
module spi_stat_summary #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] flags,
  output logic [1:0]   summary
);
  logic all_set;
  logic any_set;

  assign all_set = &flags;
  assign any_set = |flags;

  always_comb begin
    if (all_set)      summary = 2'b11;
    else if (any_set) summary = 2'b01;
    else              summary = 2'b00;
  end
endmodule

// File: rtl/spi_stat_core.sv
module spi_stat_core
  import spi_stat_pkg::*;
#(
  parameter logic [BYTE_W-1:0] OPC_READ  = OPC_READ_DEF,
  parameter logic [BYTE_W-1:0] OPC_WRITE = OPC_WRITE_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              mosi,
  input  logic [BYTE_W-1:0] stat_live,
  input  logic              wel,
  output logic              miso,
  output logic              miso_oe,
  output logic              lock,
  output logic              wel_clr
);
  phase_t            phase;
  logic              sck_q;
  logic [CNT_W-1:0]  bcnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] snap;
  logic              wr_full;
  logic              wr_bit;
  logic              sck_rise;
  logic              sck_fall;
  logic [BYTE_W-1:0] next_byte;
  logic              last_bit;

  assign sck_rise  = sck & ~sck_q;
  assign sck_fall  = ~sck & sck_q;
  assign next_byte = {shreg[BYTE_W-2:0], mosi};
  assign last_bit  = (bcnt == CNT_W'(BYTE_W-1));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_OPCODE;
      sck_q   <= 1'b0;
      bcnt    <= '0;
      shreg   <= '0;
      snap    <= '0;
      wr_full <= 1'b0;
      wr_bit  <= 1'b0;
      miso    <= 1'b0;
      miso_oe <= 1'b0;
      lock    <= 1'b0;
      wel_clr <= 1'b0;
    end else begin
      sck_q   <= sck;
      wel_clr <= 1'b0;
      if (cs_n) begin
        if (phase == PH_WDATA && wr_full && bcnt == '0 && wel) begin
          lock    <= wr_bit;
          wel_clr <= 1'b1;
        end
        phase   <= PH_OPCODE;
        bcnt    <= '0;
        wr_full <= 1'b0;
        miso_oe <= 1'b0;
      end else begin
        unique case (phase)
          PH_OPCODE: if (sck_rise) begin
            shreg <= next_byte;
            bcnt  <= bcnt + 1'b1;
            if (last_bit) begin
              if (next_byte == OPC_READ)       phase <= PH_STREAM;
              else if (next_byte == OPC_WRITE) phase <= PH_WDATA;
              else                             phase <= PH_SKIP;
            end
          end
          PH_STREAM: if (sck_fall) begin
            if (bcnt == '0) begin
              miso <= stat_live[BYTE_W-1];
              snap <= stat_live;
            end else begin
              miso <= snap[~bcnt];
            end
            miso_oe <= 1'b1;
            bcnt    <= bcnt + 1'b1;
          end
          PH_WDATA: if (sck_rise) begin
            shreg <= next_byte;
            bcnt  <= bcnt + 1'b1;
            if (last_bit) begin
              wr_full <= 1'b1;
              wr_bit  <= next_byte[BYTE_W-1];
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_status_resp.sv
module spi_status_resp
  import spi_stat_pkg::*;
#(
  parameter int unsigned NUM_SECT    = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                spi_sck,
  input  logic                spi_cs_n,
  input  logic                spi_mosi,
  output logic                spi_miso,
  output logic                spi_miso_oe,
  input  logic                busy_i,
  input  logic                wel_i,
  input  logic                wp_n_i,
  input  logic                err_i,
  input  logic [NUM_SECT-1:0] sect_prot_i,
  output logic                lock_o,
  output logic                wel_clr_o
);
  logic [2:0]        pins_s;
  logic [1:0]        sect_sum;
  logic [BYTE_W-1:0] stat_live;

  spi_stat_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({spi_sck, spi_cs_n, spi_mosi}),
    .dout (pins_s)
  );

  spi_stat_summary #(.N(NUM_SECT)) u_sum (
    .flags   (sect_prot_i),
    .summary (sect_sum)
  );

  assign stat_live = {lock_o, 1'b0, err_i, wp_n_i, sect_sum, wel_i, busy_i};

  spi_stat_core u_core (
    .clk       (clk),
    .rst       (rst),
    .sck       (pins_s[2]),
    .cs_n      (pins_s[1]),
    .mosi      (pins_s[0]),
    .stat_live (stat_live),
    .wel       (wel_i),
    .miso      (spi_miso),
    .miso_oe   (spi_miso_oe),
    .lock      (lock_o),
    .wel_clr   (wel_clr_o)
  );
endmodule

// File: rtl/spi_status_resp_chk.sv
module spi_status_resp_chk #(
  parameter int unsigned NUM_SECT = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                spi_cs_n,
  input logic                spi_miso_oe,
  input logic                wel_i,
  input logic                lock_o,
  input logic                wel_clr_o,
  input logic [NUM_SECT-1:0] sect_prot_i,
  input logic [7:0]          stat_live
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!spi_miso_oe && !lock_o && !wel_clr_o));

  // R6
  deselect_hiz_chk: assert property (@(posedge clk) disable iff (rst)
    (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3)
     && $past(spi_cs_n, 4)) |-> !spi_miso_oe);

  // R8
  clr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wel_clr_o |=> !wel_clr_o);

  // R8
  clr_needs_wel_chk: assert property (@(posedge clk) disable iff (rst)
    wel_clr_o |-> $past(wel_i));

  // R9
  lock_guard_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(lock_o) |-> wel_clr_o);

  // R4
  summary_full_chk: assert property (@(posedge clk) disable iff (rst)
    (&sect_prot_i) |-> (stat_live[3:2] == 2'b11));

  // R4
  summary_none_chk: assert property (@(posedge clk) disable iff (rst)
    (sect_prot_i == '0) |-> (stat_live[3:2] == 2'b00));
endmodule

bind spi_status_resp spi_status_resp_chk #(.NUM_SECT(NUM_SECT)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .spi_cs_n    (spi_cs_n),
  .spi_miso_oe (spi_miso_oe),
  .wel_i       (wel_i),
  .lock_o      (lock_o),
  .wel_clr_o   (wel_clr_o),
  .sect_prot_i (sect_prot_i),
  .stat_live   (stat_live)
);

// File: tb/tb_spi_status_resp.sv
`timescale 1ns/1ps
module tb_spi_status_resp;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, miso_oe;
  logic busy = 1'b0, wel = 1'b0, wp_n = 1'b1, err = 1'b0;
  logic [7:0] sect = 8'h00;
  logic lock, wel_clr;

  int checks = 0, failures = 0, clr_count = 0;
  bit oe_seen = 1'b0, done = 1'b0;

  always #4 clk = ~clk;

  spi_status_resp dut (
    .clk(clk), .rst(rst), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_oe(miso_oe), .busy_i(busy), .wel_i(wel),
    .wp_n_i(wp_n), .err_i(err), .sect_prot_i(sect), .lock_o(lock),
    .wel_clr_o(wel_clr)
  );

  always @(posedge clk) begin
    if (wel_clr) clr_count++;
    if (miso_oe) oe_seen = 1'b1;
  end

  // fields: sect, {busy, wel, wp_n, err}, expected word
  localparam logic [19:0] VEC [6] = '{
    {8'h00, 4'b0010, 8'h10},
    {8'hFF, 4'b1000, 8'h0D},
    {8'h01, 4'b0111, 8'h36},
    {8'h80, 4'b1101, 8'h27},
    {8'hFE, 4'b0000, 8'h04},
    {8'hFF, 4'b0110, 8'h1E}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_in(input logic [7:0] s, input logic [3:0] f);
    sect = s; {busy, wel, wp_n, err} = f;
  endtask

  task automatic spi_bit(input logic din, output logic dout);
    mosi = din;
    repeat (H) @(negedge clk);
    dout = miso;
    sck = 1'b1;
    repeat (H) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      spi_bit(tx[i], b);
      rx = {rx[6:0], b};
    end
  endtask

  task automatic sel;
    cs_n = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic desel;
    cs_n = 1'b1;
    repeat (2*H) @(negedge clk);
  endtask

  task automatic read_once(output logic [7:0] w);
    logic [7:0] d;
    sel();
    xfer(8'h05, d);
    xfer(8'h00, w);
    desel();
  endtask

  initial begin
    repeat (2000 * H) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] w, d;
    logic b;
    repeat (4) @(negedge clk);
    check("R1 oe in reset", {7'd0, miso_oe}, 8'h00);
    rst = 1'b0;
    @(negedge clk);
    check("R1 oe/lock/clr after reset", {5'd0, miso_oe, lock, wel_clr}, 8'h00);

    // R3 R4: table walk, includes busy=1 reads
    for (int i = 0; i < 6; i++) begin
      set_in(VEC[i][19:12], VEC[i][11:8]);
      read_once(w);
      check($sformatf("R3/R4 vector %0d", i), w, VEC[i][7:0]);
    end

    // R2: oe low during opcode, first bit right after
    set_in(8'h00, 4'b0010);
    sel();
    xfer(8'h05, d);
    check("R2 oe after opcode", {7'd0, miso_oe}, 8'h00);
    xfer(8'h00, w);
    check("R2 first byte", w, 8'h10);
    desel();

    // R5: repeating word with fresh snapshots, stable mid-byte
    set_in(8'h00, 4'b1010);
    sel();
    xfer(8'h05, d);
    xfer(8'h00, w);
    check("R5 byte1", w, 8'h11);
    set_in(8'h3C, 4'b0001);
    w = '0;
    for (int i = 0; i < 3; i++) begin spi_bit(1'b0, b); w = {w[6:0], b}; end
    set_in(8'hFF, 4'b0110);
    for (int i = 0; i < 5; i++) begin spi_bit(1'b0, b); w = {w[6:0], b}; end
    check("R5 byte2 held", w, 8'h24);
    xfer(8'h00, w);
    check("R5 byte3 fresh", w, 8'h1E);
    desel();

    // R6: abort mid-byte
    set_in(8'h00, 4'b0010);
    sel();
    xfer(8'h05, d);
    for (int i = 0; i < 3; i++) spi_bit(1'b0, b);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R6 oe after abort", {7'd0, miso_oe}, 8'h00);
    repeat (2*H) @(negedge clk);
    read_once(w);
    check("R6 read after abort", w, 8'h10);

    // R7: unknown opcode
    oe_seen = 1'b0;
    sel();
    xfer(8'h9F, d);
    xfer(8'h00, w);
    xfer(8'h00, w);
    check("R7 oe never raised", {7'd0, oe_seen}, 8'h00);
    desel();

    // R9: write without enable
    set_in(8'h00, 4'b0010);
    sel(); xfer(8'h01, d); xfer(8'h80, d); desel();
    check("R9 lock with wel=0", {6'd0, lock, 1'b0}, 8'h00);
    check("R9 no clr pulse", 8'(clr_count), 8'd0);

    // R8: enabled write sets lock, other bits stay input-driven
    set_in(8'h00, 4'b0110);
    sel(); xfer(8'h01, d); xfer(8'hFF, d); desel();
    check("R8 lock set", {7'd0, lock}, 8'h01);
    check("R8 clr pulse", 8'(clr_count), 8'd1);
    read_once(w);
    check("R8 word after write", w, 8'h92);

    // R9: partial byte leaves lock
    sel(); xfer(8'h01, d); xfer(8'h00, d);
    for (int i = 0; i < 3; i++) spi_bit(1'b0, b);
    desel();
    check("R9 partial byte", {7'd0, lock}, 8'h01);
    check("R9 partial no clr", 8'(clr_count), 8'd1);

    // R8: clear lock
    sel(); xfer(8'h01, d); xfer(8'h00, d); desel();
    check("R8 lock cleared", {7'd0, lock}, 8'h00);
    check("R8 second clr", 8'(clr_count), 8'd2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule